// File: doc/BRIEF.md
# Warp Instruction Issue Sequencer

This block sits between a set of resident warps and a group of pipelined functional-unit lanes. Each warp raises a ready flag when its next instruction can go, and presents an instruction tag beside it. The sequencer picks one ready warp by round-robin and issues that warp's instruction for all 32 threads. The lane group is narrower than a warp, so the instruction goes out as a run of lane-sized slices, one slice per cycle. Slice k covers threads k*LANES up to k*LANES+LANES-1. The lanes are pipelined, so slices leave on back-to-back cycles.

A new instruction can start only while the lanes report that they are available. If availability drops partway through an instruction, the current slice is held until the lanes come back. The sequencer changes warp only after the last slice of an instruction has gone out. On that last slice it pulses an acknowledge for the issuing warp, so that the warp's ready source can clear. A warp's ready flag and tag are looked at only on the cycle its instruction starts. If the last slice and the next start fall on adjacent cycles, instructions follow with no idle cycle between them.

Top module: `warp_issue_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, `issueValid` and `warpAck` are 0. After reset the round-robin search starts at warp 0.
- R2: An instruction issues exactly WARP_SIZE/LANES slices, with `issueSlice` running 0, 1, 2 and so on. While `laneAvail` stays high, the slices go out on consecutive cycles.
- R3: On a slice cycle, bits [k*LANES +: LANES] of `issueMask` are 1 for slice index k, and every other bit is 0. When `issueValid` is 0, `issueMask` is all zero.
- R4: `issueWarp` and `issueTag` stay constant across all slices of one instruction. `issueTag` equals the tag that the chosen warp presented on `warpTag[w*TAG_W +: TAG_W]` in the cycle slice 0 issued.
- R5: A new instruction starts, meaning slice 0 issues, only in a cycle where `laneAvail` is 1. No slice of any kind issues while `laneAvail` is 0.
- R6: If `laneAvail` drops partway through an instruction, no slice issues while it is low. Once it returns, the same warp continues with the slice index that was next.
- R7: Only a warp whose `warpReady` bit is 1 in the start cycle can be chosen. If no warp is ready, nothing issues.
- R8: Among the ready warps, the one chosen is the first found when searching upward, with wrap-around, from the warp after the last warp that started an instruction.
- R9: `warpAck` is one-hot or zero. It is 1 only for bit `issueWarp`, and only on the cycle in which the last slice (index WARP_SIZE/LANES-1) issues.
- R10: Changes of `warpReady` while an instruction is still issuing slices have no effect on which warp issues the remaining slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| warpReady | input | NUM_WARPS | Per-warp flag: the next instruction is ready |
| warpTag | input | NUM_WARPS*TAG_W | Per-warp instruction tag, warp w at [w*TAG_W +: TAG_W] |
| laneAvail | input | 1 | The functional-unit lanes can accept a slice this cycle |
| issueValid | output | 1 | A slice issues this cycle |
| issueWarp | output | clog2(NUM_WARPS) | Warp that owns the slice |
| issueTag | output | TAG_W | Tag of the instruction being issued |
| issueSlice | output | clog2(WARP_SIZE/LANES) | Slice index within the instruction |
| issueMask | output | WARP_SIZE | Threads covered by this slice |
| warpAck | output | NUM_WARPS | One-hot pulse on the last slice of the issuing warp |

## Verification
A slice counter that is out of step with the busy state shows up at the ports within one instruction. It appears as a missing or repeated slice index, a mask window in the wrong place, or an acknowledge that comes early, comes late, or never comes. A stale round-robin pointer or stale captured warp register shows on the very next start. The effect is a wrong `issueWarp`, or a change of warp in the middle of an instruction. The stimulus covers several such cases: ready flags that change during an instruction, tags that change every cycle, lane stalls both before a start and mid-instruction, and a reset in the middle of an instruction. These make each of those faults visible within a few cycles.

// File: rtl/wis_pkg.sv
package wis_pkg;
  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic start;    // slice 0 of a new instruction issues now
    logic advance;  // a later slice of the current instruction issues now
    logic finish;   // the slice issuing now is the last one
  } wis_ctrl_t;
endpackage

// File: rtl/wis_ctrl.sv
module wis_ctrl
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int SLICES    = 4,
  parameter int WID_W     = 2,
  parameter int SLICE_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warpReady,
  input  logic                 laneAvail,
  output wis_ctrl_t            ctrl,
  output logic [WID_W-1:0]     grantWarp,
  output logic [SLICE_W-1:0]   sliceIdx,
  output logic                 busy
);
  logic [WID_W-1:0] rrPtr;
  logic             anyReady;
  logic             lastSlice;
  logic             issueNow;

  // Round-robin search upward from rrPtr, wrapping around
  always_comb begin
    anyReady  = 1'b0;
    grantWarp = '0;
    for (int k = 0; k < NUM_WARPS; k++) begin
      int cand;
      cand = (int'(rrPtr) + k) % NUM_WARPS;
      if (!anyReady && warpReady[cand]) begin
        anyReady  = 1'b1;
        grantWarp = WID_W'(cand);
      end
    end
  end

  assign lastSlice    = (sliceIdx == SLICE_W'(SLICES - 1));
  assign ctrl.start   = !rst && !busy && anyReady && laneAvail;
  assign ctrl.advance = !rst && busy && laneAvail;
  assign issueNow     = ctrl.start || ctrl.advance;
  assign ctrl.finish  = issueNow && lastSlice;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      sliceIdx <= '0;
      rrPtr    <= '0;
    end else begin
      if (ctrl.start) begin
        rrPtr <= (int'(grantWarp) == NUM_WARPS - 1) ? '0 : grantWarp + 1'b1;
      end
      if (issueNow) begin
        if (lastSlice) begin
          busy     <= 1'b0;
          sliceIdx <= '0;
        end else begin
          busy     <= 1'b1;
          sliceIdx <= sliceIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wis_datapath.sv
module wis_datapath
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int TAG_W     = 8,
  parameter int LANES     = 8,
  parameter int WARP_SIZE = 32,
  parameter int SLICES    = 4,
  parameter int WID_W     = 2,
  parameter int SLICE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  wis_ctrl_t                  ctrl,
  input  logic [WID_W-1:0]           grantWarp,
  input  logic [SLICE_W-1:0]         sliceIdx,
  input  logic                       busy,
  input  logic [NUM_WARPS*TAG_W-1:0] warpTag,
  output logic                       issueValid,
  output logic [WID_W-1:0]           issueWarp,
  output logic [TAG_W-1:0]           issueTag,
  output logic [WARP_SIZE-1:0]       issueMask,
  output logic [NUM_WARPS-1:0]       warpAck
);
  logic [WID_W-1:0] curWarp;
  logic [TAG_W-1:0] curTag;
  logic [TAG_W-1:0] grantTag;

  assign grantTag   = warpTag[int'(grantWarp)*TAG_W +: TAG_W];
  assign issueValid = ctrl.start || ctrl.advance;
  assign issueWarp  = busy ? curWarp : grantWarp;
  assign issueTag   = busy ? curTag  : grantTag;

  always_ff @(posedge clk) begin
    if (rst) begin
      curWarp <= '0;
      curTag  <= '0;
    end else if (ctrl.start) begin
      curWarp <= grantWarp;
      curTag  <= grantTag;
    end
  end

  // One lane-sized window of the thread mask per slice
  for (genvar k = 0; k < SLICES; k++) begin : g_mask
    assign issueMask[k*LANES +: LANES] =
      {LANES{issueValid && (sliceIdx == SLICE_W'(k))}};
  end

  always_comb begin
    warpAck = '0;
    if (ctrl.finish) warpAck[issueWarp] = 1'b1;
  end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 4,
  parameter int TAG_W     = 8,
  parameter int LANES     = 8,
  parameter int WARP_SIZE = 32,
  localparam int SLICES   = WARP_SIZE / LANES,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int SLICE_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WARPS-1:0]       warpReady,
  input  logic [NUM_WARPS*TAG_W-1:0] warpTag,
  input  logic                       laneAvail,
  output logic                       issueValid,
  output logic [WID_W-1:0]           issueWarp,
  output logic [TAG_W-1:0]           issueTag,
  output logic [SLICE_W-1:0]         issueSlice,
  output logic [WARP_SIZE-1:0]       issueMask,
  output logic [NUM_WARPS-1:0]       warpAck
);
  wis_ctrl_t          ctrl;
  logic [WID_W-1:0]   grantWarp;
  logic [SLICE_W-1:0] sliceIdx;
  logic               busy;

  wis_ctrl #(
    .NUM_WARPS(NUM_WARPS), .SLICES(SLICES), .WID_W(WID_W), .SLICE_W(SLICE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .warpReady(warpReady), .laneAvail(laneAvail),
    .ctrl(ctrl), .grantWarp(grantWarp), .sliceIdx(sliceIdx), .busy(busy)
  );

  wis_datapath #(
    .NUM_WARPS(NUM_WARPS), .TAG_W(TAG_W), .LANES(LANES), .WARP_SIZE(WARP_SIZE),
    .SLICES(SLICES), .WID_W(WID_W), .SLICE_W(SLICE_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .grantWarp(grantWarp),
    .sliceIdx(sliceIdx), .busy(busy), .warpTag(warpTag),
    .issueValid(issueValid), .issueWarp(issueWarp), .issueTag(issueTag),
    .issueMask(issueMask), .warpAck(warpAck)
  );

  assign issueSlice = sliceIdx;
endmodule

// File: rtl/warp_issue_seq_chk.sv
module warp_issue_seq_chk #(
  parameter int NUM_WARPS = 4,
  parameter int TAG_W     = 8,
  parameter int LANES     = 8,
  parameter int WARP_SIZE = 32,
  localparam int SLICES   = WARP_SIZE / LANES,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int SLICE_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_WARPS-1:0]       warpReady,
  input logic [NUM_WARPS*TAG_W-1:0] warpTag,
  input logic                       laneAvail,
  input logic                       issueValid,
  input logic [WID_W-1:0]           issueWarp,
  input logic [TAG_W-1:0]           issueTag,
  input logic [SLICE_W-1:0]         issueSlice,
  input logic [WARP_SIZE-1:0]       issueMask,
  input logic [NUM_WARPS-1:0]       warpAck
);
  always @(posedge clk) begin
    if (rst) begin
      AST_QUIET_IN_RESET: assert (!issueValid && warpAck == '0); // R1
    end
  end

  AST_LANES_NEEDED: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> laneAvail); // R5

  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> ($countones(issueMask) == LANES)); // R3

  AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !issueValid |-> (issueMask == '0)); // R3

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(warpAck)); // R9

  AST_ACK_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (warpAck != '0) |-> (issueValid && issueSlice == SLICE_W'(SLICES - 1)
                         && warpAck[issueWarp])); // R9

  AST_SLICE_STEP: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueSlice != SLICE_W'(SLICES - 1)) |=>
      (!issueValid || (issueSlice == $past(issueSlice) + 1'b1
                       && issueWarp == $past(issueWarp)
                       && issueTag == $past(issueTag)))); // R2

  AST_START_READY: assert property (@(posedge clk) disable iff (rst)
    (issueValid && issueSlice == '0) |-> warpReady[issueWarp]); // R7
endmodule

bind warp_issue_seq warp_issue_seq_chk #(
  .NUM_WARPS(NUM_WARPS), .TAG_W(TAG_W), .LANES(LANES), .WARP_SIZE(WARP_SIZE)
) u_chk (.*);

// File: tb/warp_issue_seq_bench.sv
module warp_issue_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int TW = 8;
  localparam int LN = 8;
  localparam int WS = 32;
  localparam int NVEC = 20;

  // Vector: {ready[3:0], laneAvail, expValid, expWarp[1:0], expSlice[1:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'b1111, 1'b1, 1'b1, 2'd0, 2'd0},  // 0 first start after reset: warp 0
    {4'b1111, 1'b1, 1'b1, 2'd0, 2'd1},
    {4'b0000, 1'b1, 1'b1, 2'd0, 2'd2},  // ready dropped mid-instruction
    {4'b0000, 1'b0, 1'b0, 2'd0, 2'd0},  // mid stall
    {4'b0000, 1'b1, 1'b1, 2'd0, 2'd3},  // resume, last slice
    {4'b1111, 1'b0, 1'b0, 2'd0, 2'd0},  // ready but no lanes
    {4'b1111, 1'b1, 1'b1, 2'd1, 2'd0},  // round-robin to warp 1
    {4'b1111, 1'b1, 1'b1, 2'd1, 2'd1},
    {4'b1111, 1'b1, 1'b1, 2'd1, 2'd2},
    {4'b1111, 1'b1, 1'b1, 2'd1, 2'd3},
    {4'b0001, 1'b1, 1'b1, 2'd0, 2'd0},  // only warp 0 ready, wrap
    {4'b0000, 1'b1, 1'b1, 2'd0, 2'd1},
    {4'b0000, 1'b1, 1'b1, 2'd0, 2'd2},
    {4'b0000, 1'b1, 1'b1, 2'd0, 2'd3},
    {4'b0000, 1'b1, 1'b0, 2'd0, 2'd0},  // nobody ready
    {4'b1001, 1'b1, 1'b1, 2'd3, 2'd0},  // pointer at 1: warp 3 first
    {4'b1001, 1'b1, 1'b1, 2'd3, 2'd1},
    {4'b1001, 1'b1, 1'b1, 2'd3, 2'd2},
    {4'b1001, 1'b1, 1'b1, 2'd3, 2'd3},
    {4'b1001, 1'b1, 1'b1, 2'd0, 2'd0}   // pointer wrapped to 0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NW-1:0]    warpReady = '0;
  logic [NW*TW-1:0] warpTag = '0;
  logic             laneAvail = 1'b0;
  logic             issueValid;
  logic [1:0]       issueWarp;
  logic [TW-1:0]    issueTag;
  logic [1:0]       issueSlice;
  logic [WS-1:0]    issueMask;
  logic [NW-1:0]    warpAck;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  warp_issue_seq #(.NUM_WARPS(NW), .TAG_W(TW), .LANES(LN), .WARP_SIZE(WS))
  u_warp_issue_seq (
    .clk(clk), .rst(rst), .warpReady(warpReady), .warpTag(warpTag),
    .laneAvail(laneAvail), .issueValid(issueValid), .issueWarp(issueWarp),
    .issueTag(issueTag), .issueSlice(issueSlice), .issueMask(issueMask),
    .warpAck(warpAck)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WS-1:0] maskFor(input int s);
    return {{(WS-LN){1'b0}}, {LN{1'b1}}} << (s*LN);
  endfunction

  task automatic setTags(input int seed);
    for (int w = 0; w < NW; w++) warpTag[w*TW +: TW] = TW'((w << 5) | seed);
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] startTag;
    startTag = '0;
    rst = 1'b1; warpReady = '1; laneAvail = 1'b1; setTags(0);
    @(negedge clk);
    check(!issueValid, "R1 valid in reset", 64'(issueValid), 0);
    check(warpAck == '0, "R1 ack in reset", 64'(warpAck), 0);
    @(posedge clk); #1;
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      logic [NW-1:0] expAck;
      v = VEC[i];
      warpReady = v[9:6];
      laneAvail = v[5];
      setTags(i);
      @(negedge clk);
      check(issueValid == v[4], "R5 R6 R7 valid", 64'(issueValid), 64'(v[4]));
      expAck = (v[4] && v[1:0] == 2'd3) ? NW'(1) << v[3:2] : '0;
      check(warpAck == expAck, "R9 ack", 64'(warpAck), 64'(expAck));
      if (v[4]) begin
        if (v[1:0] == 2'd0) startTag = TW'((int'(v[3:2]) << 5) | i);
        check(issueWarp == v[3:2], "R8 R10 warp", 64'(issueWarp), 64'(v[3:2]));
        check(issueSlice == v[1:0], "R2 slice", 64'(issueSlice), 64'(v[1:0]));
        check(issueTag == startTag, "R4 tag", 64'(issueTag), 64'(startTag));
        check(issueMask == maskFor(int'(v[1:0])), "R3 mask",
              64'(issueMask), 64'(maskFor(int'(v[1:0]))));
      end else begin
        check(issueMask == '0, "R3 idle mask", 64'(issueMask), 0);
      end
      @(posedge clk); #1;
    end

    // Reset in the middle of an instruction (warp 0 is at slice 1 now)
    rst = 1'b1; warpReady = '1; laneAvail = 1'b1;
    @(negedge clk);
    check(!issueValid, "R1 valid in mid-instruction reset", 64'(issueValid), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check(issueValid && issueWarp == 2'd0 && issueSlice == 2'd0,
          "R1 restart at warp 0", 64'({issueValid, issueWarp, issueSlice}),
          64'({1'b1, 2'd0, 2'd0}));
    @(posedge clk); #1;

    // No warp ready: nothing starts once the current instruction drains
    warpReady = '0;
    for (int i = 0; i < 3; i++) begin @(posedge clk); #1; end
    @(negedge clk);
    check(!issueValid, "R7 idle with no ready warp", 64'(issueValid), 0);
    @(posedge clk); #1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule